// File: doc/BRIEF.md
# Magnetometer Axis and Set/Reset Sequencer

This block drives the digital side of a three-axis analog magnetometer front end. The front end has one multiplexed output, so only one axis can be read at a time. The block picks that axis through a two-bit select output. It also owns a single set/reset line: each transition of this line fires a short, strong field pulse across the sensor. A host issues one of two commands through a valid/ready port. The first command selects an axis. The second command runs a set/reset operation.

A set/reset operation inverts the line from whatever level it holds. The block then waits a fixed gap and inverts the line again, so the line returns to its starting level. After that it enforces a long settling lockout before readings can be trusted again. The gap and the lockout are parameters counted in clock cycles; their defaults are 2 us and 3 s at 250 MHz.

While an operation or its lockout runs, the block reports busy and withdraws axis-valid. A request that arrives during that time is held in a one-entry slot and runs once the lockout ends. At reset the block selects the Y axis and holds the set/reset line low.

Top module: `mag_srst_seq`

## Requirements
- R1: After reset the select output {selMsb, selLsb} is 2'b00 (Y), srstLine is low, busy is low, axisValid is high and reqReady is high.
- R2: A request with reqKind = 0 selects an axis using the code on reqAxis: X = 2'b01, Y = 2'b00, Z = 2'b10. If the request is accepted on clock edge t while the block is idle, the code appears on {selMsb, selLsb} after edge t+1.
- R3: A select request carrying code 2'b11 is accepted and consumed. It leaves the select output unchanged and does not raise busy.
- R4: A request with reqKind = 1 runs set/reset. If it is accepted on edge t while idle, srstLine inverts from its present level on edge t+1, and busy rises on that same edge.
- R5: The second inversion of srstLine comes exactly GAP_CYCLES clock edges after the first. This returns the line to its starting level.
- R6: busy stays high, and axisValid stays low, from the first inversion until SETTLE_CYCLES edges after the second inversion. busy is therefore high for GAP_CYCLES + SETTLE_CYCLES cycles in total.
- R7: The request slot holds one entry. reqReady is low while an entry waits. A request accepted during busy is held, and it takes effect one edge after busy falls.
- R8: The select output never changes while busy is high, and srstLine never changes while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Request slot empty; a request is taken when valid and ready are both high |
| reqKind | input | 1 | 0 = axis select, 1 = set/reset |
| reqAxis | input | 2 | Axis code for select requests |
| selMsb | output | 1 | Axis select, upper bit |
| selLsb | output | 1 | Axis select, lower bit |
| srstLine | output | 1 | Set/reset toggle line |
| busy | output | 1 | Set/reset or settle lockout in progress |
| axisValid | output | 1 | Selected axis output may be read |

## Verification
Results fall due at fixed offsets from the edge that accepts a request:
- A new select code, or the first inversion of the set/reset line, appears one edge after acceptance.
- The second inversion follows GAP_CYCLES edges after the first.
- busy falls SETTLE_CYCLES edges after the second inversion.
- A held request takes effect one edge after busy falls.

The bench drives inputs on the falling edge and samples on the falling edge as well. Each output is compared against a behavioural model that advances on every rising edge. On top of that, the bench timestamps the line inversions and counts busy cycles, so the gap and lockout lengths are measured directly against the parameters.

// File: rtl/mag_seq_pkg.sv
package mag_seq_pkg;

  // Axis select codes as driven on {selMsb, selLsb}
  typedef enum logic [1:0] {
    AXIS_Y   = 2'b00,
    AXIS_X   = 2'b01,
    AXIS_Z   = 2'b10,
    AXIS_BAD = 2'b11
  } axis_code_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_GAP    = 2'd1,
    PH_SETTLE = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic popSlot;
    logic applySel;
    logic flipLine;
    logic cntClear;
    logic cntStep;
  } strobe_t;

endpackage

// File: rtl/mag_seq_dp.sv
module mag_seq_dp
  import mag_seq_pkg::*;
#(
  parameter int unsigned GAP_CYCLES    = 500,
  parameter int unsigned SETTLE_CYCLES = 750_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqKind,
  input  logic [1:0] reqAxis,
  input  strobe_t    stb,
  output logic       slotFull,
  output logic       slotKind,
  output logic       gapHit,
  output logic       settleHit,
  output logic [1:0] selCode,
  output logic       lineLevel
);

  localparam int unsigned MAX_CNT = (GAP_CYCLES > SETTLE_CYCLES) ? GAP_CYCLES : SETTLE_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] GAP_LAST    = CNT_W'(GAP_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [1:0]       slotAxis;
  logic [CNT_W-1:0] cnt;
  logic             pushSlot;

  assign pushSlot = reqValid && !slotFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotFull <= 1'b0;
      slotKind <= 1'b0;
      slotAxis <= AXIS_Y;
    end else if (pushSlot) begin
      slotFull <= 1'b1;
      slotKind <= reqKind;
      slotAxis <= reqAxis;
    end else if (stb.popSlot) begin
      slotFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selCode <= AXIS_Y;
    end else if (stb.applySel && slotAxis != AXIS_BAD) begin
      selCode <= slotAxis;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lineLevel <= 1'b0;
    else if (stb.flipLine) lineLevel <= ~lineLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.cntClear) cnt <= '0;
    else if (stb.cntStep) cnt <= cnt + 1'b1;
  end

  assign gapHit    = (cnt == GAP_LAST);
  assign settleHit = (cnt == SETTLE_LAST);

endmodule

// File: rtl/mag_seq_ctrl.sv
module mag_seq_ctrl
  import mag_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    slotFull,
  input  logic    slotKind,
  input  logic    gapHit,
  input  logic    settleHit,
  output strobe_t stb,
  output logic    busy
);

  phase_t phase, phaseNext;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    stb       = '0;
    unique case (phase)
      PH_IDLE: begin
        if (slotFull) begin
          stb.popSlot = 1'b1;
          if (slotKind) begin
            stb.flipLine = 1'b1;
            stb.cntClear = 1'b1;
            phaseNext    = PH_GAP;
          end else begin
            stb.applySel = 1'b1;
          end
        end
      end
      PH_GAP: begin
        if (gapHit) begin
          stb.flipLine = 1'b1;
          stb.cntClear = 1'b1;
          phaseNext    = PH_SETTLE;
        end else begin
          stb.cntStep = 1'b1;
        end
      end
      PH_SETTLE: begin
        if (settleHit) phaseNext = PH_IDLE;
        else stb.cntStep = 1'b1;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/mag_srst_seq.sv
module mag_srst_seq
  import mag_seq_pkg::*;
#(
  parameter int unsigned GAP_CYCLES    = 500,
  parameter int unsigned SETTLE_CYCLES = 750_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       reqKind,
  input  logic [1:0] reqAxis,
  output logic       selMsb,
  output logic       selLsb,
  output logic       srstLine,
  output logic       busy,
  output logic       axisValid
);

  strobe_t    stb;
  logic       slotFull, slotKind, gapHit, settleHit;
  logic [1:0] selCode;

  mag_seq_dp #(
    .GAP_CYCLES   (GAP_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqAxis  (reqAxis),
    .stb      (stb),
    .slotFull (slotFull),
    .slotKind (slotKind),
    .gapHit   (gapHit),
    .settleHit(settleHit),
    .selCode  (selCode),
    .lineLevel(srstLine)
  );

  mag_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotFull (slotFull),
    .slotKind (slotKind),
    .gapHit   (gapHit),
    .settleHit(settleHit),
    .stb      (stb),
    .busy     (busy)
  );

  assign reqReady  = !slotFull;
  assign selMsb    = selCode[1];
  assign selLsb    = selCode[0];
  assign axisValid = !busy;

endmodule

// File: rtl/mag_seq_chk.sv
module mag_seq_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic selMsb,
  input logic selLsb,
  input logic srstLine,
  input logic busy,
  input logic axisValid
);

  // R3
  no_bad_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(selMsb && selLsb));

  // R4
  flip_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$stable(srstLine));

  // R6
  valid_low_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !axisValid);

  // R7
  slot_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !busy) |=> !reqReady);

  // R8
  sel_hold_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable({selMsb, selLsb}));

  // R8
  line_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(srstLine) |-> busy);

endmodule

bind mag_srst_seq mag_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .selMsb   (selMsb),
  .selLsb   (selLsb),
  .srstLine (srstLine),
  .busy     (busy),
  .axisValid(axisValid)
);

// File: tb/mag_srst_seq_bench.sv
module mag_srst_seq_bench;

  localparam int GAP    = 6;
  localparam int SETTLE = 25;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqKind = 1'b0;
  logic [1:0] reqAxis = 2'b00;
  logic       reqReady, selMsb, selLsb, srstLine, busy, axisValid;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mag_srst_seq #(.GAP_CYCLES(GAP), .SETTLE_CYCLES(SETTLE)) u_mag_srst_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqAxis(reqAxis), .selMsb(selMsb), .selLsb(selLsb),
    .srstLine(srstLine), .busy(busy), .axisValid(axisValid)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  bit mFull, mKind, mLine;
  int mAxis, mSel, mPhase, mCnt;

  always @(posedge clk) begin
    bit oldFull;
    cyc++;
    if (!rstN) begin
      mFull = 0; mKind = 0; mAxis = 0; mSel = 0; mLine = 0; mPhase = 0; mCnt = 0;
    end else begin
      oldFull = mFull;
      if (mPhase == 0) begin
        if (mFull) begin
          if (mKind) begin mLine = !mLine; mPhase = 1; mCnt = 0; end
          else if (mAxis != 3) mSel = mAxis;
          mFull = 0;
        end
      end else if (mPhase == 1) begin
        if (mCnt == GAP - 1) begin mLine = !mLine; mPhase = 2; mCnt = 0; end
        else mCnt++;
      end else begin
        if (mCnt == SETTLE - 1) mPhase = 0;
        else mCnt++;
      end
      if (reqValid && !oldFull) begin
        mFull = 1; mKind = reqKind; mAxis = int'(reqAxis);
      end
    end
  end

  // Per-cycle comparison and timing monitor
  bit prevLine = 0;
  int flips = 0, tFirst = 0, tSecond = 0, busyCnt = 0, validLowCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 sel", int'({selMsb, selLsb}), mSel);
      chk("R4 line", int'(srstLine), int'(mLine));
      chk("R6 busy", int'(busy), int'(mPhase != 0));
      chk("R7 ready", int'(reqReady), int'(!mFull));
      if (srstLine != prevLine) begin
        flips++;
        if (flips % 2 == 1) tFirst = cyc; else tSecond = cyc;
      end
      prevLine = srstLine;
      if (busy) busyCnt++;
      if (!axisValid) validLowCnt++;
    end
  end

  task automatic send(bit k, logic [1:0] a);
    @(negedge clk);
    reqKind = k; reqAxis = a; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic selAxis(logic [1:0] a, int exp, string tag);
    send(1'b0, a);
    @(negedge clk);
    chk(tag, int'({selMsb, selLsb}), exp);
    chk({tag, " busy"}, int'(busy), 0);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sel", int'({selMsb, selLsb}), 0);
    chk("R1 line", int'(srstLine), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 valid", int'(axisValid), 1);
    chk("R1 ready", int'(reqReady), 1);

    // R2 select encodings
    selAxis(2'b01, 1, "R2 X");
    selAxis(2'b10, 2, "R2 Z");
    selAxis(2'b00, 0, "R2 Y");
    selAxis(2'b01, 1, "R2 X again");
    // R3 illegal code ignored
    selAxis(2'b11, 1, "R3 bad code");

    // R4/R5/R6 set/reset operation
    busyCnt = 0; validLowCnt = 0;
    send(1'b1, 2'b00);
    @(negedge clk);
    chk("R4 first flip", int'(srstLine), 1);
    chk("R4 busy", int'(busy), 1);
    chk("R6 valid", int'(axisValid), 0);
    waitIdle();
    chk("R5 gap", tSecond - tFirst, GAP);
    chk("R5 level back", int'(srstLine), 0);
    chk("R6 busy length", busyCnt, GAP + SETTLE);
    chk("R6 valid length", validLowCnt, GAP + SETTLE);
    chk("R6 valid back", int'(axisValid), 1);

    // R7 request held during busy; R8 select frozen
    send(1'b1, 2'b00);
    @(negedge clk);
    send(1'b0, 2'b10);
    chk("R7 ready low", int'(reqReady), 0);
    chk("R8 sel frozen", int'({selMsb, selLsb}), 1);
    waitIdle();
    chk("R7 not yet", int'({selMsb, selLsb}), 1);
    @(negedge clk);
    chk("R7 applied", int'({selMsb, selLsb}), 2);
    chk("R7 ready back", int'(reqReady), 1);

    // back-to-back set/reset operations through the slot
    send(1'b1, 2'b00);
    send(1'b1, 2'b00);
    @(negedge clk);
    waitIdle();
    @(negedge clk);
    chk("R7 second op ran", int'(busy), 1);
    waitIdle();
    chk("R5 level final", int'(srstLine), 0);
    chk("R5 flips total", flips, 8);
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<%0d cycles", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule